// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block chooses the address of the next instruction to fetch. Each cycle it takes the current program counter, the 32-bit instruction just fetched and the two register operands that the instruction names. From these it produces the next program counter. It decodes the control-flow opcodes directly: the two equality branches, the four sign-test branches, the region jump, the jump-with-link and the jump through a register. Every other instruction falls through to the sequential address.

The block is purely combinational and sits between fetch and the PC register. It also drives a taken flag, which the surrounding pipeline can use to redirect fetch. For the jump-with-link it raises a write request for register 31 and presents the return address, which is the current PC plus 8.

Instruction fields used throughout: the opcode is bits [31:26], rs is [25:21], rt is [20:16], the function code is [5:0], the 16-bit offset is [15:0] and the 26-bit jump index is [25:0].

Top module: `npc_unit`

## Requirements
- R1: When no branch or jump is taken, `npc_o` equals `pc_i + 4` and `taken_o` is 0.
- R2: Opcode 0x04 is taken when `rs_val_i == rt_val_i`. Opcode 0x05 is taken when they differ.
- R3: A taken conditional branch sets `npc_o = pc_i + 4 + (sign-extended offset << 2)`, with modulo-2^32 wrap.
- R4: Opcode 0x01 decodes the rt field [20:16] as a sub-code. Sub-code 0 is taken when rs is negative, and sub-code 1 is taken when rs is zero or positive. Any other sub-code falls through to `pc_i + 4`.
- R5: Opcode 0x06 is taken when rs is at most 0, and opcode 0x07 is taken when rs is greater than 0. Both tests are signed two's complement.
- R6: Opcode 0x02 sets `npc_o` to {bits [31:28] of `pc_i + 4`, bits [25:0] of the instruction, 2'b00}.
- R7: Opcode 0x03 uses the same target as R6 and raises `link_we_o`. `link_val_o` always equals `pc_i + 8`.
- R8: Opcode 0x00 with function 0x08 sets `npc_o` to `rs_val_i`.
- R9: `taken_o` is 1 for every taken branch and every jump (R6, R7, R8), and 0 otherwise.
- R10: Every other opcode, and opcode 0x00 with any other function, gives `npc_o = pc_i + 4`. In all these cases, and for every opcode except 0x03, `link_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | Value of the register in field rs |
| rt_val_i | input | 32 | Value of the register in field rt |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Branch taken or jump |
| link_we_o | output | 1 | Write request for register 31 |
| link_val_o | output | 32 | Return address, PC + 8 |

## Verification
The hardest cases to reach are those where the incremented PC carries into the top four bits just before a region jump, and where a negative branch offset wraps the address below zero. Random PCs almost never land on these. Directed vectors therefore place the PC at the last word of a 256 MB region and near address 0. The sign tests depend on exact operand values at 0, -1, 0x7FFFFFFF and 0x80000000. The random stimulus draws operands from a pool that favours those values, and it makes rs equal to rt about half the time.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_SIGNTST = 6'h01;
  localparam logic [5:0] OPC_JMP     = 6'h02;
  localparam logic [5:0] OPC_JLINK   = 6'h03;
  localparam logic [5:0] OPC_BREQ    = 6'h04;
  localparam logic [5:0] OPC_BRNE    = 6'h05;
  localparam logic [5:0] OPC_BRLE    = 6'h06;
  localparam logic [5:0] OPC_BRGT    = 6'h07;
  localparam logic [5:0] FN_JREG     = 6'h08;

  typedef enum logic [3:0] {
    FL_SEQ, FL_EQ, FL_NE, FL_LTZ, FL_GEZ, FL_LEZ, FL_GTZ,
    FL_JMP, FL_JLINK, FL_JREG
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0] instr_i,
  output flow_e       kind_o,
  output logic [15:0] off_o,
  output logic [25:0] idx_o
);
  logic [5:0] opc;
  logic [4:0] sub;
  logic [5:0] fn;

  assign opc   = instr_i[31:26];
  assign sub   = instr_i[20:16];
  assign fn    = instr_i[5:0];
  assign off_o = instr_i[15:0];
  assign idx_o = instr_i[25:0];

  always_comb begin
    kind_o = FL_SEQ;
    unique case (opc)
      OPC_SPECIAL: if (fn == FN_JREG) kind_o = FL_JREG;
      OPC_SIGNTST: begin
        if (sub == 5'd0)      kind_o = FL_LTZ;
        else if (sub == 5'd1) kind_o = FL_GEZ;
      end
      OPC_JMP:   kind_o = FL_JMP;
      OPC_JLINK: kind_o = FL_JLINK;
      OPC_BREQ:  kind_o = FL_EQ;
      OPC_BRNE:  kind_o = FL_NE;
      OPC_BRLE:  kind_o = FL_LEZ;
      OPC_BRGT:  kind_o = FL_GTZ;
      default:   kind_o = FL_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_e           kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);
  logic neg, zero, same;

  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);
  assign same = (a_i == b_i);

  always_comb begin
    unique case (kind_i)
      FL_EQ:    take_o = same;
      FL_NE:    take_o = !same;
      FL_LTZ:   take_o = neg;
      FL_GEZ:   take_o = !neg;
      FL_LEZ:   take_o = neg || zero;
      FL_GTZ:   take_o = !neg && !zero;
      FL_JMP,
      FL_JLINK,
      FL_JREG:  take_o = 1'b1;
      default:  take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_e           kind_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [15:0]     off_i,
  input  logic [25:0]     idx_i,
  input  logic [XLEN-1:0] rs_i,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] link_o
);
  localparam int unsigned EXT_W = XLEN - 18;
  localparam int unsigned HI_W  = XLEN - 28;

  logic [XLEN-1:0] seq, br_tgt, reg_tgt;

  assign seq     = pc_i + XLEN'(4);
  assign link_o  = pc_i + XLEN'(8);
  assign br_tgt  = seq + {{EXT_W{off_i[15]}}, off_i, 2'b00};
  // region target keeps the top bits of the incremented PC
  assign reg_tgt = {seq[XLEN-1:XLEN-HI_W], idx_i, 2'b00};

  always_comb begin
    npc_o = seq;
    if (take_i) begin
      unique case (kind_i)
        FL_JMP, FL_JLINK: npc_o = reg_tgt;
        FL_JREG:          npc_o = rs_i;
        default:          npc_o = br_tgt;
      endcase
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] npc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o
);
  flow_e       kind;
  logic [15:0] off;
  logic [25:0] idx;
  logic        take;

  npc_decode u_dec (
    .instr_i (instr_i),
    .kind_o  (kind),
    .off_o   (off),
    .idx_o   (idx)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (kind),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .take_o (take)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .kind_i (kind),
    .take_i (take),
    .pc_i   (pc_i),
    .off_i  (off),
    .idx_i  (idx),
    .rs_i   (rs_val_i),
    .npc_o  (npc_o),
    .link_o (link_val_o)
  );

  assign taken_o   = take;
  assign link_we_o = (kind == FL_JLINK);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] npc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o
);
  always_comb begin
    // R1
    seq_when_idle_chk: assert (taken_o || npc_o == pc_i + XLEN'(4));
    // R2
    eq_taken_chk: assert (!(instr_i[31:26] == 6'h04 && rs_val_i == rt_val_i) || taken_o);
    // R6
    region_low_chk: assert (!(instr_i[31:26] == 6'h02) || npc_o[27:0] == {instr_i[25:0], 2'b00});
    // R7
    link_addr_chk: assert (link_val_o == pc_i + XLEN'(8));
    // R8
    reg_jump_chk: assert (!(instr_i[31:26] == 6'h00 && instr_i[5:0] == 6'h08) || npc_o == rs_val_i);
    // R10
    link_only_jal_chk: assert (!link_we_o || (instr_i[31:26] == 6'h03 && taken_o));
  end
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .npc_o      (npc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pc, ins, rsv, rtv, npc, lval;
  logic        tk, lwe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  npc_unit u0 (
    .pc_i(pc), .instr_i(ins), .rs_val_i(rsv), .rt_val_i(rtv),
    .npc_o(npc), .taken_o(tk), .link_we_o(lwe), .link_val_o(lval)
  );

  typedef struct packed {
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [31:0] lval;
  } exp_t;

  function automatic exp_t model(logic [31:0] p, logic [31:0] i,
                                 logic [31:0] a, logic [31:0] b);
    exp_t e;
    logic [31:0] s, br, jt;
    logic c;
    s  = p + 32'd4;
    br = s + {{14{i[15]}}, i[15:0], 2'b00};
    jt = {s[31:28], i[25:0], 2'b00};
    c  = 1'b0;
    e.npc = s; e.tk = 1'b0; e.lwe = 1'b0; e.lval = p + 32'd8;
    case (i[31:26])
      6'h00: if (i[5:0] == 6'h08) begin e.npc = a; e.tk = 1'b1; end
      6'h01: begin
        if (i[20:16] == 5'd0) c = $signed(a) < 0;
        else if (i[20:16] == 5'd1) c = $signed(a) >= 0;
      end
      6'h02: begin e.npc = jt; e.tk = 1'b1; end
      6'h03: begin e.npc = jt; e.tk = 1'b1; e.lwe = 1'b1; end
      6'h04: c = (a == b);
      6'h05: c = (a != b);
      6'h06: c = $signed(a) <= 0;
      6'h07: c = $signed(a) > 0;
      default: ;
    endcase
    if (c) begin e.npc = br; e.tk = 1'b1; end
    return e;
  endfunction

  function automatic string req_of(logic [31:0] i);
    case (i[31:26])
      6'h00: return (i[5:0] == 6'h08) ? "R8" : "R10";
      6'h01: return (i[20:16] < 5'd2) ? "R4" : "R10";
      6'h02: return "R6";
      6'h03: return "R7";
      6'h04, 6'h05: return "R2";
      6'h06, 6'h07: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(logic [31:0] p, logic [31:0] i, logic [31:0] a,
                       logic [31:0] b, string req);
    exp_t e;
    @(posedge clk);
    pc = p; ins = i; rsv = a; rtv = b;
    e = model(p, i, a, b);
    @(negedge clk);
    checks++;
    if (npc !== e.npc || tk !== e.tk || lwe !== e.lwe || lval !== e.lval) begin
      errors++;
      $display("FAIL %s ins=%h pc=%h: npc=%h tk=%b lwe=%b lval=%h expected npc=%h tk=%b lwe=%b lval=%h",
               req, i, p, npc, tk, lwe, lval, e.npc, e.tk, e.lwe, e.lval);
    end
  endtask

  function automatic logic [31:0] pick_val(int unsigned r);
    case (r % 8)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] i, a, b;
    void'($urandom(32'd4177));
    pc = '0; ins = '0; rsv = '0; rtv = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero word is not a jump -> R1
    @(negedge clk);
    checks++;
    if (npc !== 32'd4 || tk !== 1'b0 || lwe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: npc=%h tk=%b lwe=%b expected 00000004 0 0", npc, tk, lwe);
    end
    // R1 / R10 sequential
    apply(32'h0000_1000, 32'h0000_0021, 32'h5, 32'h5, "R1");
    apply(32'h0000_1000, 32'hFC00_0000, 32'h0, 32'h0, "R10");
    apply(32'h0040_0000, 32'h0000_0009, 32'h1234, 32'h0, "R10");
    // R2 / R3 equality, positive and negative offsets, wrap below zero
    apply(32'h0000_0100, 32'h1000_0003, 32'h7, 32'h7, "R3");
    apply(32'h0000_0100, 32'h1000_0003, 32'h7, 32'h8, "R2");
    apply(32'h0000_0004, 32'h1400_FFF0, 32'h1, 32'h2, "R3");
    apply(32'hFFFF_FFF8, 32'h1000_0004, 32'h0, 32'h0, "R3");
    // R4 sign tests and stray sub-code
    apply(32'h0000_2000, 32'h0400_0010, 32'h8000_0000, 32'h0, "R4");
    apply(32'h0000_2000, 32'h0401_0010, 32'h0, 32'h0, "R4");
    apply(32'h0000_2000, 32'h0402_0010, 32'h0, 32'h0, "R4");
    // R5 boundaries
    apply(32'h0000_3000, 32'h1800_0008, 32'h0, 32'h0, "R5");
    apply(32'h0000_3000, 32'h1C00_0008, 32'h0, 32'h0, "R5");
    apply(32'h0000_3000, 32'h1C00_0008, 32'h7FFF_FFFF, 32'h0, "R5");
    apply(32'h0000_3000, 32'h1800_0008, 32'h1, 32'h0, "R5");
    // R6 / R7 region carry from PC+4
    apply(32'h2FFF_FFFC, 32'h0800_0040, 32'h0, 32'h0, "R6");
    apply(32'h0FFF_FFFC, 32'h0FFF_FFFF, 32'h0, 32'h0, "R7");
    // R8 / R9 register jump
    apply(32'h0000_5000, 32'h0060_0008, 32'hDECA_FE00, 32'h0, "R8");
    // random mix, R9 covered on every vector
    for (int n = 0; n < 3000; n++) begin
      int unsigned sel;
      sel = $urandom % 10;
      i = $urandom;
      case (sel)
        0: i = {6'h00, i[25:6], ($urandom % 2) ? 6'h08 : i[5:0]};
        1: i = {6'h01, i[25:21], 5'($urandom % 4), i[15:0]};
        2: i[31:26] = 6'h02;
        3: i[31:26] = 6'h03;
        4: i[31:26] = 6'h04;
        5: i[31:26] = 6'h05;
        6: i[31:26] = 6'h06;
        7: i[31:26] = 6'h07;
        default: ;
      endcase
      a = pick_val($urandom);
      b = ($urandom % 2) ? a : pick_val($urandom);
      apply({$urandom} & 32'hFFFF_FFFC, i, a, b, req_of(i));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule